// File: doc/BRIEF.md
# Disk Controller Host Command Interface

This block is the host-facing register interface of a sector-based disk controller. A byte-wide bus reaches four port offsets. Offset 0 is the data port, offset 1 returns status on a read and resets the interface on a write, offset 2 returns the DIP switch byte on a read and performs a select on a write, and offset 3 is a write-only control register. The host writes a command block through the data port, byte by byte. The first byte is the opcode, and it fixes how many bytes the block holds. The interface steps the status handshake bits along a fixed sequence while it collects the bytes.

Once the last command byte arrives, the interface waits a programmable number of cycles. It then either starts an external execution engine with a one-cycle pulse, or, if the addressed drive is absent, fails the command itself. The engine reports completion with a done strobe, an error flag, an error code and the address where it stopped. The interface then builds a result block of one, two or five bytes. It raises every completion status bit and pulses one of two interrupt outputs, chosen by DIP bit 6. The host reads the result block back through the data port.

Top module: `hdc_host_if`

## Requirements
- R1: After reset, the status port (offset 1) reads 0x05, which is command (0x04) plus ready (0x01). A data port read returns 0xFF, both interrupt outputs are low and `dma_mode` is low.
- R2: A read at offset 1 returns the status byte. A read at offset 2 returns `dip_sw`. A read at offset 3 returns 0xFF. A data port read returns 0xFF whenever no result byte is pending. Status bits: ready 0x01, input 0x02, command 0x04, select 0x08, request 0x10, interrupt 0x20.
- R3: A command block is 6 bytes, opcode included. Opcode 0x0C takes 14 bytes. Accepting the opcode clears ready and input and then sets request and ready. Every later collected byte sets ready.
- R4: The accepted opcodes are 0x00, 0x01, 0x03–0x08, 0x0A–0x0F, 0xE0 and 0xE3–0xE6. Any other opcode collects no more bytes and posts at once the result block 0x22, 0x00. It never pulses `exec_start`.
- R5: Accepting the final command byte clears command, request and ready and sets input. `exec_start` is high for exactly one cycle, beginning DELAY_CYC clock edges after the edge that accepted that byte.
- R6: The first result byte carries the addressed drive (byte 1, bit 5, of the command) in bit 5 and the error flag in bit 1. On error, the error code follows. If bit 7 of the code is set, three more bytes follow: {2'b00, drive, head[4:0]}, then {cyl[9:8], sector[5:0]}, then cyl[7:0].
- R7: Posting a result sets interrupt, input, request, command and ready. In the next cycle it pulses `irq5` for one cycle if `dip_sw[6]` is 1, and `irq2` otherwise.
- R8: Each data port read returns the next result byte and clears interrupt. The read of the last byte clears input, request and select, sets command and returns the block to idle.
- R9: Any write to offset 1 sets status to 0x05 and abandons any collection, wait or result in progress. A following data port read returns 0xFF, and the next data write starts a new command.
- R10: A write to offset 2 clears interrupt and sets select.
- R11: `dma_mode` is high exactly when the last value written to offset 3 has a nonzero value in bits 1:0.
- R12: If the drive a command addresses is absent (`drive_present[drive]` is 0) when the wait ends, the result block is {csb with error}, 0x04, and `exec_start` stays low.
- R13: Data port writes made while a command is waiting, executing or holding a result have no effect on status or on the result block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Host write strobe, one per cycle |
| bus_rd | input | 1 | Host read strobe, one per cycle |
| bus_addr | input | 2 | Port offset |
| bus_wdata | input | 8 | Host write data |
| bus_rdata | output | 8 | Host read data (combinational from offset and state) |
| dip_sw | input | 8 | Configuration switch byte; bit 6 selects the interrupt line |
| drive_present | input | 2 | One bit per drive, 1 = drive fitted |
| dma_mode | output | 1 | Transfer mode from the control register |
| exec_start | output | 1 | One-cycle start pulse to the execution engine |
| exec_opcode | output | 8 | Opcode of the command being executed |
| exec_done | input | 1 | Completion strobe from the execution engine |
| exec_err | input | 1 | Command failed |
| exec_code | input | 8 | Error code reported on failure |
| exec_head | input | 5 | Head where execution stopped |
| exec_sector | input | 6 | Sector where execution stopped |
| exec_cyl | input | 10 | Cylinder where execution stopped |
| irq5 | output | 1 | Completion interrupt pulse, line 5 |
| irq2 | output | 1 | Completion interrupt pulse, line 2 |

## Verification
A wrong collection count appears within a cycle. The status port would show the input bit early or late, or request still set after the last byte. A corrupted result pointer or count appears on the data port at the very next read, as a wrong byte, or as 0xFF where a sense byte belongs. A miscounted wait moves `exec_start` by one or more cycles. The bench compares the data, interrupt, start and mode outputs against its model on every clock, so any such slip shows in the first cycle it affects.

// File: rtl/hdc_pkg.sv
package hdc_pkg;
  localparam logic [7:0] ST_RDY = 8'h01;
  localparam logic [7:0] ST_INP = 8'h02;
  localparam logic [7:0] ST_CMD = 8'h04;
  localparam logic [7:0] ST_SEL = 8'h08;
  localparam logic [7:0] ST_REQ = 8'h10;
  localparam logic [7:0] ST_INT = 8'h20;
  localparam logic [7:0] OPC_SETPARAM = 8'h0C;
  localparam int BASE_LEN  = 6;
  localparam int EXTRA_LEN = 8;
  localparam int RES_MAX   = 5;

  typedef enum logic [2:0] {
    S_IDLE, S_COLLECT, S_WAIT, S_EXEC, S_RESULT
  } hdc_state_e;
endpackage

// File: rtl/hdc_cmd_decode.sv
module hdc_cmd_decode
  import hdc_pkg::*;
(
  input  logic [7:0] opcode,
  output logic       valid,
  output logic [3:0] blk_len
);
  always_comb begin
    valid = 1'b0;
    unique case (opcode) inside
      8'h00, 8'h01, [8'h03:8'h08], [8'h0A:8'h0F], 8'hE0, [8'hE3:8'hE6]: valid = 1'b1;
      default: valid = 1'b0;
    endcase
    blk_len = (opcode == OPC_SETPARAM) ? 4'(BASE_LEN + EXTRA_LEN) : 4'(BASE_LEN);
  end
endmodule

// File: rtl/hdc_delay_timer.sv
module hdc_delay_timer #(
  parameter int DELAY_CYC = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic run,
  output logic expired
);
  localparam int CNT_W = (DELAY_CYC > 1) ? $clog2(DELAY_CYC) : 1;

  logic [CNT_W-1:0] cnt_q, cnt_d;

  assign expired = (cnt_q == '0);

  always_comb begin
    cnt_d = cnt_q;
    if (load) cnt_d = CNT_W'(DELAY_CYC - 1);
    else if (run && !expired) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/hdc_result_fmt.sv
module hdc_result_fmt
  import hdc_pkg::*;
(
  input  logic             drive,
  input  logic             err,
  input  logic [7:0]       code,
  input  logic [4:0]       head,
  input  logic [5:0]       sector,
  input  logic [9:0]       cyl,
  output logic [RES_MAX-1:0][7:0] bytes,
  output logic [2:0]       count
);
  always_comb begin
    bytes[0] = {2'b00, drive, 3'b000, err, 1'b0};
    bytes[1] = code;
    bytes[2] = {2'b00, drive, head};
    bytes[3] = {cyl[9:8], sector};
    bytes[4] = cyl[7:0];
    if (!err)         count = 3'd1;
    else if (code[7]) count = 3'd5;
    else              count = 3'd2;
  end
endmodule

// File: rtl/hdc_host_if.sv
module hdc_host_if
  import hdc_pkg::*;
#(
  parameter int DELAY_CYC = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [1:0]  bus_addr,
  input  logic [7:0]  bus_wdata,
  output logic [7:0]  bus_rdata,
  input  logic [7:0]  dip_sw,
  input  logic [1:0]  drive_present,
  output logic        dma_mode,
  output logic        exec_start,
  output logic [7:0]  exec_opcode,
  input  logic        exec_done,
  input  logic        exec_err,
  input  logic [7:0]  exec_code,
  input  logic [4:0]  exec_head,
  input  logic [5:0]  exec_sector,
  input  logic [9:0]  exec_cyl,
  output logic        irq5,
  output logic        irq2
);
  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rs_q;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_int_n = rs_q[1];

  hdc_state_e state_q, state_d;
  logic [7:0] stat_q, stat_d;
  logic [7:0] op_q, op_d;
  logic [3:0] idx_q, idx_d, len_q, len_d;
  logic       drv_q, drv_d;
  logic [1:0] ctrl_q, ctrl_d;
  logic [RES_MAX-1:0][7:0] res_q, res_d;
  logic [2:0] rcnt_q, rcnt_d, rptr_q, rptr_d;
  logic       exec_q, exec_d, irq5_q, irq2_q;
  logic       post;

  logic       dec_valid;
  logic [3:0] dec_len;
  logic       tmr_load, tmr_expired;
  logic       fmt_drive, fmt_err;
  logic [7:0] fmt_code;
  logic [RES_MAX-1:0][7:0] fmt_bytes;
  logic [2:0] fmt_cnt;

  logic wr_data, wr_rst, wr_sel, wr_ctl, rd_data;
  assign wr_data = bus_wr && (bus_addr == 2'd0);
  assign wr_rst  = bus_wr && (bus_addr == 2'd1);
  assign wr_sel  = bus_wr && (bus_addr == 2'd2);
  assign wr_ctl  = bus_wr && (bus_addr == 2'd3);
  assign rd_data = bus_rd && (bus_addr == 2'd0);

  hdc_cmd_decode u_dec (.opcode(bus_wdata), .valid(dec_valid), .blk_len(dec_len));

  hdc_delay_timer #(.DELAY_CYC(DELAY_CYC)) u_tmr (
    .clk(clk), .rst_n(rst_int_n), .load(tmr_load),
    .run(state_q == S_WAIT), .expired(tmr_expired)
  );

  hdc_result_fmt u_fmt (
    .drive(fmt_drive), .err(fmt_err), .code(fmt_code), .head(exec_head),
    .sector(exec_sector), .cyl(exec_cyl), .bytes(fmt_bytes), .count(fmt_cnt)
  );

  // next-state logic
  always_comb begin
    state_d = state_q; stat_d = stat_q; op_d = op_q; idx_d = idx_q; len_d = len_q;
    drv_d = drv_q; ctrl_d = ctrl_q; res_d = res_q; rcnt_d = rcnt_q; rptr_d = rptr_q;
    exec_d = 1'b0; post = 1'b0; tmr_load = 1'b0;
    fmt_drive = drv_q; fmt_err = exec_err; fmt_code = exec_code;
    if (wr_rst) begin
      state_d = S_IDLE; stat_d = ST_CMD | ST_RDY; idx_d = '0; rcnt_d = '0; rptr_d = '0;
    end else begin
      if (wr_sel) stat_d = (stat_d & ~ST_INT) | ST_SEL;
      if (wr_ctl) ctrl_d = bus_wdata[1:0];
      unique case (state_q)
        S_IDLE: if (wr_data) begin
          op_d   = bus_wdata;
          stat_d = stat_d & ~(ST_RDY | ST_INP);
          if (dec_valid) begin
            state_d = S_COLLECT; len_d = dec_len; idx_d = 4'd1;
            stat_d  = stat_d | ST_REQ | ST_RDY;
          end else begin
            fmt_drive = 1'b1; fmt_err = 1'b1; fmt_code = 8'h00; post = 1'b1;
          end
        end
        S_COLLECT: if (wr_data) begin
          if (idx_q == 4'd1) drv_d = bus_wdata[5];
          idx_d  = idx_q + 4'd1;
          stat_d = stat_d | ST_RDY;
          if (idx_d == len_q) begin
            stat_d  = (stat_d & ~(ST_CMD | ST_REQ | ST_RDY)) | ST_INP;
            state_d = S_WAIT; tmr_load = 1'b1;
          end
        end
        S_WAIT: if (tmr_expired) begin
          if (drive_present[drv_q]) begin
            exec_d = 1'b1; state_d = S_EXEC;
          end else begin
            fmt_err = 1'b1; fmt_code = 8'h04; post = 1'b1;
          end
        end
        S_EXEC: if (exec_done) post = 1'b1;
        S_RESULT: if (rd_data) begin
          rptr_d = rptr_q + 3'd1;
          stat_d = stat_d & ~ST_INT;
          if (rptr_d == rcnt_q) begin
            stat_d  = (stat_d & ~(ST_INP | ST_REQ | ST_SEL)) | ST_CMD;
            state_d = S_IDLE;
          end
        end
        default: state_d = S_IDLE;
      endcase
      if (post) begin
        stat_d  = stat_d | ST_INT | ST_INP | ST_REQ | ST_CMD | ST_RDY;
        state_d = S_RESULT; res_d = fmt_bytes; rcnt_d = fmt_cnt; rptr_d = '0;
      end
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      state_q <= S_IDLE; stat_q <= ST_CMD | ST_RDY; op_q <= '0; idx_q <= '0;
      len_q <= '0; drv_q <= 1'b0; ctrl_q <= '0; res_q <= '0; rcnt_q <= '0;
      rptr_q <= '0; exec_q <= 1'b0; irq5_q <= 1'b0; irq2_q <= 1'b0;
    end else begin
      state_q <= state_d; stat_q <= stat_d; op_q <= op_d; idx_q <= idx_d;
      len_q <= len_d; drv_q <= drv_d; ctrl_q <= ctrl_d; res_q <= res_d;
      rcnt_q <= rcnt_d; rptr_q <= rptr_d; exec_q <= exec_d;
      irq5_q <= post && dip_sw[6];
      irq2_q <= post && !dip_sw[6];
    end
  end

  always_comb begin
    unique case (bus_addr)
      2'd0:    bus_rdata = (state_q == S_RESULT) ? res_q[rptr_q] : 8'hFF;
      2'd1:    bus_rdata = stat_q;
      2'd2:    bus_rdata = dip_sw;
      default: bus_rdata = 8'hFF;
    endcase
  end

  assign dma_mode    = (ctrl_q != 2'b00);
  assign exec_start  = exec_q;
  assign exec_opcode = op_q;
  assign irq5        = irq5_q;
  assign irq2        = irq2_q;

  // assertions
  a_r7_irq_exclusive: assert property (@(posedge clk) disable iff (!rst_int_n)
    !(irq5 && irq2));
  a_r7_irq_single: assert property (@(posedge clk) disable iff (!rst_int_n)
    (irq5 || irq2) |=> !(irq5 || irq2));
  a_r7_irq_with_int: assert property (@(posedge clk) disable iff (!rst_int_n)
    (irq5 || irq2) |-> (stat_q[5] && state_q == S_RESULT));
  a_r5_start_single: assert property (@(posedge clk) disable iff (!rst_int_n)
    exec_start |=> !exec_start);
  a_r5_wait_status: assert property (@(posedge clk) disable iff (!rst_int_n)
    (state_q == S_WAIT) |-> ((stat_q & 8'h17) == 8'h02));
  a_r8_result_ptr: assert property (@(posedge clk) disable iff (!rst_int_n)
    (state_q == S_RESULT) |-> (rcnt_q != 3'd0 && rptr_q < rcnt_q));
  a_r12_start_present: assert property (@(posedge clk) disable iff (!rst_int_n)
    exec_start |-> (state_q == S_EXEC));
endmodule

// File: tb/hdc_host_if_tb_top.sv
module hdc_host_if_tb_top;
  localparam int DLY = 16;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n = 1'b0;
  logic bus_wr = 0, bus_rd = 0;
  logic [1:0] bus_addr = 2'd1;
  logic [7:0] bus_wdata = 8'h00, bus_rdata;
  logic [7:0] dip_sw = 8'h40;
  logic [1:0] drive_present = 2'b11;
  logic dma_mode, exec_start, irq5, irq2;
  logic [7:0] exec_opcode;
  logic exec_done = 0, exec_err = 0;
  logic [7:0] exec_code = 8'h00;
  logic [4:0] exec_head = 5'd0;
  logic [5:0] exec_sector = 6'd0;
  logic [9:0] exec_cyl = 10'd0;

  hdc_host_if #(.DELAY_CYC(DLY)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .dip_sw(dip_sw),
    .drive_present(drive_present), .dma_mode(dma_mode), .exec_start(exec_start),
    .exec_opcode(exec_opcode), .exec_done(exec_done), .exec_err(exec_err),
    .exec_code(exec_code), .exec_head(exec_head), .exec_sector(exec_sector),
    .exec_cyl(exec_cyl), .irq5(irq5), .irq2(irq2)
  );

  int n_cmp = 0, n_bad = 0, n_exec = 0;
  bit cmp_on = 0, finished = 0;

  task automatic chk(string tag, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // behavioural reference model: 0 idle, 1 collect, 2 wait, 3 exec, 4 result
  int m_state = 0, m_len = 0, m_idx = 0, m_timer = 0;
  logic [7:0] m_stat = 8'h05;
  logic [7:0] mq[$];
  bit m_drv = 0, m_dma = 0, m_ex = 0, m_i5 = 0, m_i2 = 0;

  function bit op_ok(logic [7:0] op);
    case (op)
      8'h00, 8'h01, 8'h03, 8'h04, 8'h05, 8'h06, 8'h07, 8'h08, 8'h0A, 8'h0B,
      8'h0C, 8'h0D, 8'h0E, 8'h0F, 8'hE0, 8'hE3, 8'hE4, 8'hE5, 8'hE6: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function void m_post(bit d, bit e, logic [7:0] c);
    mq.delete();
    mq.push_back({2'b00, d, 3'b000, e, 1'b0});
    if (e) begin
      mq.push_back(c);
      if (c[7]) begin
        mq.push_back({2'b00, d, exec_head});
        mq.push_back({exec_cyl[9:8], exec_sector});
        mq.push_back(exec_cyl[7:0]);
      end
    end
    m_stat = m_stat | 8'h37;
    m_i5 = dip_sw[6]; m_i2 = !dip_sw[6];
    m_state = 4;
  endfunction

  always @(posedge clk) begin : model
    int st0;
    m_ex = 0; m_i5 = 0; m_i2 = 0;
    if (!rst_n) begin
      m_state = 0; m_stat = 8'h05; mq.delete(); m_dma = 0;
    end else if (bus_wr && bus_addr == 2'd1) begin
      m_state = 0; m_stat = 8'h05; mq.delete();
    end else begin
      st0 = m_state;
      if (bus_wr && bus_addr == 2'd2) m_stat = (m_stat & ~8'h20) | 8'h08;
      if (bus_wr && bus_addr == 2'd3) m_dma = (bus_wdata[1:0] != 2'b00);
      case (st0)
        0: if (bus_wr && bus_addr == 2'd0) begin
             m_stat = m_stat & ~8'h03;
             if (op_ok(bus_wdata)) begin
               m_state = 1; m_len = (bus_wdata == 8'h0C) ? 14 : 6; m_idx = 1;
               m_stat = m_stat | 8'h11;
             end else m_post(1'b1, 1'b1, 8'h00);
           end
        1: if (bus_wr && bus_addr == 2'd0) begin
             if (m_idx == 1) m_drv = bus_wdata[5];
             m_idx++;
             m_stat = m_stat | 8'h01;
             if (m_idx == m_len) begin
               m_stat = (m_stat & ~8'h15) | 8'h02; m_state = 2; m_timer = DLY - 1;
             end
           end
        2: if (m_timer == 0) begin
             if (drive_present[m_drv]) begin m_ex = 1; m_state = 3; end
             else m_post(m_drv, 1'b1, 8'h04);
           end else m_timer--;
        3: if (exec_done) m_post(m_drv, exec_err, exec_code);
        4: if (bus_rd && bus_addr == 2'd0) begin
             void'(mq.pop_front());
             m_stat = m_stat & ~8'h20;
             if (mq.size() == 0) begin m_stat = (m_stat & ~8'h1A) | 8'h04; m_state = 0; end
           end
        default: m_state = 0;
      endcase
    end
  end

  // per-clock comparison and execution engine stub
  int stub_cnt = 0;
  always @(negedge clk) begin : cmp
    logic [7:0] exp_rd;
    #2;
    if (cmp_on) begin
      case (bus_addr)
        2'd0: exp_rd = (m_state == 4 && mq.size() > 0) ? mq[0] : 8'hFF;
        2'd1: exp_rd = m_stat;
        2'd2: exp_rd = dip_sw;
        default: exp_rd = 8'hFF;
      endcase
      chk("R2 model bus_rdata", bus_rdata, exp_rd);
      chk("R7 model irq5", irq5, m_i5);
      chk("R7 model irq2", irq2, m_i2);
      chk("R5 model exec_start", exec_start, m_ex);
      chk("R11 model dma_mode", dma_mode, m_dma);
    end
    if (exec_start) n_exec++;
    exec_done = 0;
    if (exec_start) stub_cnt = 3;
    else if (stub_cnt > 0) begin
      stub_cnt--;
      if (stub_cnt == 0) exec_done = 1;
    end
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1; bus_rd = 0;
  endtask
  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1; bus_wr = 0;
    #3 d = bus_rdata;
  endtask
  task automatic idle();
    @(negedge clk); bus_wr = 0; bus_rd = 0; bus_addr = 2'd1;
  endtask
  task automatic send(input logic [7:0] b[$]);
    foreach (b[i]) wr(2'd0, b[i]);
  endtask
  task automatic wait_irq(output bit g5, output bit g2);
    g5 = 0; g2 = 0;
    @(negedge clk); bus_wr = 0; bus_rd = 0; bus_addr = 2'd1;
    #3;
    for (int i = 0; i < 200; i++) begin
      if (irq5 || irq2) begin g5 = irq5; g2 = irq2; break; end
      @(negedge clk); #3;
    end
  endtask
  task automatic get_result(string tag, input logic [7:0] e[$]);
    logic [7:0] d;
    foreach (e[i]) begin rd(2'd0, d); chk(tag, d, e[i]); end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: actual 0x0 expected 0x1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin : stim
    logic [7:0] s;
    bit g5, g2;
    int e0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    cmp_on = 1;

    // R1 / R2: reset state and port map
    rd(2'd1, s); chk("R1 status after reset", s, 8'h05);
    rd(2'd0, s); chk("R1 data idle", s, 8'hFF);
    rd(2'd2, s); chk("R2 dip read", s, 8'h40);
    rd(2'd3, s); chk("R2 offset3 read", s, 8'hFF);
    idle(); chk("R1 irq low", {30'd0, irq5, irq2}, 0);

    // R11 control register
    wr(2'd3, 8'h01); idle(); #3 chk("R11 dma on", dma_mode, 1);
    wr(2'd3, 8'h04); idle(); #3 chk("R11 dma off", dma_mode, 0);

    // 6-byte read command, drive 0, irq2 selected
    dip_sw = 8'h00;
    wr(2'd0, 8'h08);
    rd(2'd1, s); chk("R3 status after opcode", s, 8'h15);
    send('{8'h00, 8'h01, 8'h02, 8'h01, 8'h00});
    rd(2'd1, s); chk("R5 status after last byte", s, 8'h02);
    wr(2'd0, 8'hAB);
    rd(2'd1, s); chk("R13 write while waiting", s, 8'h02);
    chk("R5 opcode to engine", exec_opcode, 8'h08);
    wait_irq(g5, g2); chk("R7 irq2 chosen", {30'd0, g5, g2}, 1);
    rd(2'd1, s); chk("R7 status at post", s, 8'h37);
    wr(2'd0, 8'h55);
    rd(2'd1, s); chk("R13 write while result held", s, 8'h37);
    get_result("R6 ok result", '{8'h00});
    rd(2'd1, s); chk("R8 status after last read", s, 8'h05);
    rd(2'd0, s); chk("R8 read with nothing pending", s, 8'hFF);

    // select, then 14-byte parameter command on drive 1, irq5
    dip_sw = 8'h40;
    wr(2'd2, 8'h00);
    rd(2'd1, s); chk("R10 select", s, 8'h0D);
    send('{8'h0C, 8'h20, 8'h00, 8'h00, 8'h00, 8'h00, 8'h02, 8'h64, 8'h04,
           8'h02, 8'h65, 8'h02, 8'h65});
    rd(2'd1, s); chk("R3 still collecting at 13", s, 8'h1D);
    wr(2'd0, 8'h0B);
    rd(2'd1, s); chk("R3 done at 14", s, 8'h0A);
    wait_irq(g5, g2); chk("R7 irq5 chosen", {30'd0, g5, g2}, 2);
    rd(2'd1, s); chk("R7 status with select", s, 8'h3F);
    rd(2'd0, s); chk("R6 drive1 csb", s, 8'h20);
    rd(2'd1, s); chk("R8 select cleared", s, 8'h05);

    // unknown opcode
    dip_sw = 8'h00;
    e0 = n_exec;
    wr(2'd0, 8'h02);
    wait_irq(g5, g2); chk("R4 unknown posts at once", {30'd0, g5, g2}, 1);
    rd(2'd1, s); chk("R4 status", s, 8'h37);
    get_result("R4 unknown result", '{8'h22, 8'h00});
    rd(2'd1, s); chk("R4 back to idle", s, 8'h05);
    chk("R4 no engine start", n_exec, e0);

    // opcode 0xE5 accepted
    wr(2'd0, 8'hE5);
    rd(2'd1, s); chk("R4 E5 accepted", s, 8'h15);
    send('{8'h00, 8'h00, 8'h00, 8'h01, 8'h00});
    wait_irq(g5, g2);
    get_result("R4 E5 result", '{8'h00});

    // error with sense bytes
    exec_err = 1; exec_code = 8'h90; exec_head = 5'd3; exec_sector = 6'd5; exec_cyl = 10'h2A7;
    send('{8'h08, 8'h23, 8'h85, 8'hA7, 8'h01, 8'h00});
    wait_irq(g5, g2);
    get_result("R6 sense bytes", '{8'h22, 8'h90, 8'h23, 8'h85, 8'hA7});
    rd(2'd1, s); chk("R8 idle after sense", s, 8'h05);

    // error without sense bytes
    exec_code = 8'h11;
    send('{8'h08, 8'h00, 8'h00, 8'h00, 8'h01, 8'h00});
    wait_irq(g5, g2);
    get_result("R6 short error", '{8'h02, 8'h11});
    exec_err = 0; exec_code = 8'h00;

    // absent drive
    drive_present = 2'b01;
    e0 = n_exec;
    send('{8'h08, 8'h20, 8'h00, 8'h00, 8'h01, 8'h00});
    wait_irq(g5, g2);
    get_result("R12 absent drive", '{8'h22, 8'h04});
    chk("R12 no engine start", n_exec, e0);
    drive_present = 2'b11;

    // reset port mid-collection and mid-result
    send('{8'h08, 8'h00, 8'h00});
    wr(2'd1, 8'h00);
    rd(2'd1, s); chk("R9 status after reset write", s, 8'h05);
    rd(2'd0, s); chk("R9 data after reset write", s, 8'hFF);
    send('{8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00});
    wait_irq(g5, g2);
    get_result("R9 fresh command", '{8'h00});
    wr(2'd0, 8'h09);
    wait_irq(g5, g2);
    wr(2'd1, 8'h00);
    rd(2'd1, s); chk("R9 reset drops result", s, 8'h05);
    rd(2'd0, s); chk("R9 no result left", s, 8'hFF);
    idle(); idle();

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule